// File: doc/BRIEF.md
# Single-Channel Bus-Master DMA Controller

This block moves a programmed number of 32-bit longwords from a local memory port to a remote system bus. Software loads a local start address, a remote start address and a longword count through a small 32-bit register port, then writes a start bit in the control/status word. The engine reads one word from the local side and writes it to the remote bus. After each remote acknowledge it advances both addresses by 4 and decrements the count. It stops when the count reaches zero or when the remote bus reports an error.

The outcome is reported in sticky status flags that software clears by writing zero: successful completion, bus error, and two failure flags. One failure flag is for a bus error. The other is for an overrun, where the local source still had data when the count ran out. A gate bit, set by software once the wide base addresses are configured, must be present in the start write or the start is refused and a configuration-error flag is raised. Software can leave the remote address alone between transfers, and the next transfer then carries on from the address after the last word written. A one-cycle interrupt pulse marks the end of every transfer.

Top module: `dma_chan`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0, no request is raised on either side and `irq` is low.
- R2: Register offsets: 0x0 local address, 0x4 remote address, 0x8 count (bits 19:0 only, upper bits read 0), 0xC control/status. The status bit positions are: 0 start (write-only, reads 0), 1 done, 2 failed by bus error, 3 failed by overrun, 4 busy (read-only), 5 bus error, 12 base-ready gate, 16 configuration error. All other bits read 0. Any other offset reads 0.
- R3: A control/status write with bit 0 = 1 and bit 12 = 1, issued while idle with a nonzero count, starts a transfer. Busy and the local request are high in the cycle after the write.
- R4: A start write with bit 12 = 0, with a zero count, or while busy starts nothing and sets bit 16.
- R5: Each beat reads the local word at the local address and then writes that same word to the remote bus at the remote address. On remote acknowledge both addresses grow by 4 and the count drops by 1.
- R6: When the count reaches zero and the local side flagged the final word as last, the transfer ends and bit 1 is set.
- R7: When the count reaches zero and the final word was not flagged last, the transfer ends with bit 3 set and bit 1 clear.
- R8: A remote bus error aborts the transfer, sets bits 5 and 2, and leaves the addresses and count at the failing beat.
- R9: If it is not rewritten, the remote address register carries on from where the previous transfer stopped.
- R10: Writing 0 to bits 1, 2, 3, 5 or 16 clears them and writing 1 leaves them unchanged. Bit 12 holds the value last written.
- R11: Writes to offsets 0x0, 0x4 and 0x8 while busy are ignored.
- R12: `irq` pulses high for exactly one cycle when a transfer ends by done, overrun or bus error. It is high in the first cycle that the new status bit reads 1.
- R13: The local and remote requests are never high together. A request and its address and data stay stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lw_req | output | 1 | Local word read request |
| lw_addr | output | 32 | Local word address |
| lw_ack | input | 1 | Local word accepted, data valid |
| lw_data | input | 32 | Local word data |
| lw_last | input | 1 | Local source has no more words after this one |
| rb_req | output | 1 | Remote bus write request |
| rb_addr | output | 32 | Remote bus address |
| rb_wdata | output | 32 | Remote bus write data |
| rb_ack | input | 1 | Remote write completed |
| rb_berr | input | 1 | Remote bus error (takes priority over ack) |
| irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest conditions to reach are the collisions between software writes and a running transfer. These are a second start or an address rewrite that lands mid-transfer, and a bus error that arrives on a chosen beat while the count is still nonzero. The bench reaches them with a responder whose stall pattern and error beat index are programmed per transfer. This stretches transfers so that register writes fall inside them, and it fires the error on an exact beat. A behavioural model follows every register write and handshake. It is compared each cycle on the requests, addresses, data, interrupt and register readback, so any mistimed increment or freeze shows up in the cycle it occurs.

// File: rtl/dma_chan_pkg.sv
// Package: shared offsets, status bit positions and engine states for the
// DMA channel. Assumes a 16-byte register window decoded on 4 address bits.
package dma_chan_pkg;
    localparam logic [3:0] OFF_LADDR = 4'h0;
    localparam logic [3:0] OFF_RADDR = 4'h4;
    localparam logic [3:0] OFF_COUNT = 4'h8;
    localparam logic [3:0] OFF_CSR   = 4'hC;

    localparam int B_START = 0;
    localparam int B_DONE  = 1;
    localparam int B_FBERR = 2;
    localparam int B_FOVR  = 3;
    localparam int B_BUSY  = 4;
    localparam int B_BERR  = 5;
    localparam int B_BRDY  = 12;
    localparam int B_CFG   = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PUSH  = 2'd2
    } eng_st_t;
endpackage

// File: rtl/dma_chan_regs.sv
// Register file of the DMA channel: address and count counters, sticky
// write-zero-to-clear status flags, start qualification, read mux and the
// end-of-transfer interrupt. Assumes the engine reports beats and endings
// as single-cycle pulses and that AW <= RW.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 20,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [3:0]    addr,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata,
    input  logic          busy,
    input  logic          beat,
    input  logic          fin_done,
    input  logic          fin_ovr,
    input  logic          fin_berr,
    output logic          start,
    output logic [AW-1:0] laddr,
    output logic [AW-1:0] raddr,
    output logic          cnt_last,
    output logic          irq
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [CW-1:0] cnt;
    logic          f_done, f_fberr, f_fovr, f_berr, f_brdy, f_cfg;
    logic          wr_csr, start_req, start_ok, reg_open;
    logic          clr_done, clr_fberr, clr_fovr, clr_berr, clr_cfg;
    logic [RW-1:0] csr_view;

    // Decode a control/status write and qualify the start request.
    assign wr_csr    = wen && (addr == OFF_CSR);
    assign start_req = wr_csr && wdata[B_START];
    assign start_ok  = start_req && wdata[B_BRDY] && (cnt != '0) && !busy;
    assign start     = start_ok;
    assign reg_open  = wen && !busy;
    assign cnt_last  = (cnt == CW'(1));

    // Writing zero to a sticky flag clears it.
    assign clr_done  = wr_csr && !wdata[B_DONE];
    assign clr_fberr = wr_csr && !wdata[B_FBERR];
    assign clr_fovr  = wr_csr && !wdata[B_FOVR];
    assign clr_berr  = wr_csr && !wdata[B_BERR];
    assign clr_cfg   = wr_csr && !wdata[B_CFG];

    // Local address: loaded by software when idle, stepped per beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                            laddr <= '0;
        else if (beat)                         laddr <= laddr + STEP;
        else if (reg_open && addr == OFF_LADDR) laddr <= wdata[AW-1:0];
    end

    // Remote address: same policy; never reset by a transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n)                            raddr <= '0;
        else if (beat)                         raddr <= raddr + STEP;
        else if (reg_open && addr == OFF_RADDR) raddr <= wdata[AW-1:0];
    end

    // Longword count: loaded when idle, decremented per beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt <= '0;
        else if (beat)                         cnt <= cnt - 1'b1;
        else if (reg_open && addr == OFF_COUNT) cnt <= wdata[CW-1:0];
    end

    // Sticky flags: a hardware set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_done  <= 1'b0;
            f_fberr <= 1'b0;
            f_fovr  <= 1'b0;
            f_berr  <= 1'b0;
            f_brdy  <= 1'b0;
            f_cfg   <= 1'b0;
        end else begin
            f_done  <= (f_done  && !clr_done)  || fin_done;
            f_fberr <= (f_fberr && !clr_fberr) || fin_berr;
            f_fovr  <= (f_fovr  && !clr_fovr)  || fin_ovr;
            f_berr  <= (f_berr  && !clr_berr)  || fin_berr;
            f_brdy  <= wr_csr ? wdata[B_BRDY] : f_brdy;
            f_cfg   <= (f_cfg   && !clr_cfg)   || (start_req && !start_ok);
        end
    end

    // Interrupt pulse in the cycle the new flag first reads set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fin_done || fin_ovr || fin_berr;
    end

    // Assemble the control/status view.
    always_comb begin
        csr_view         = '0;
        csr_view[B_DONE]  = f_done;
        csr_view[B_FBERR] = f_fberr;
        csr_view[B_FOVR]  = f_fovr;
        csr_view[B_BUSY]  = busy;
        csr_view[B_BERR]  = f_berr;
        csr_view[B_BRDY]  = f_brdy;
        csr_view[B_CFG]   = f_cfg;
    end

    // Read mux over the four offsets.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_LADDR: rdata[AW-1:0] = laddr;
            OFF_RADDR: rdata[AW-1:0] = raddr;
            OFF_COUNT: rdata[CW-1:0] = cnt;
            OFF_CSR:   rdata         = csr_view;
            default:   rdata         = '0;
        endcase
    end

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> cnt == $past(cnt) - 1'b1);
    a_r8_freeze_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        fin_berr |=> (cnt == $past(cnt)) && (raddr == $past(raddr)) && (laddr == $past(laddr)));
    a_r4_busy_start_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy) |=> f_cfg);
    a_r11_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wen && addr == OFF_LADDR && !beat) |=> laddr == $past(laddr));
    a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/dma_chan_engine.sv
// Transfer sequencer of the DMA channel: alternates a local word fetch with
// a remote write of that word, one beat at a time. Assumes the register file
// steps addresses and count on the beat pulse and that rb_berr outranks
// rb_ack when both are high.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] raddr,
    input  logic          cnt_last,
    output logic          lw_req,
    output logic [AW-1:0] lw_addr,
    input  logic          lw_ack,
    input  logic [DW-1:0] lw_data,
    input  logic          lw_last,
    output logic          rb_req,
    output logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_wdata,
    input  logic          rb_ack,
    input  logic          rb_berr,
    output logic          busy,
    output logic          beat,
    output logic          fin_done,
    output logic          fin_ovr,
    output logic          fin_berr
);
    eng_st_t       st;
    logic [DW-1:0] hold_q;
    logic          last_q;

    // State sequencing: idle -> fetch -> push -> (fetch | idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (start)  st <= ST_FETCH;
                ST_FETCH: if (lw_ack) st <= ST_PUSH;
                ST_PUSH: begin
                    if (rb_berr)     st <= ST_IDLE;
                    else if (rb_ack) st <= cnt_last ? ST_IDLE : ST_FETCH;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture the fetched word and its end-of-source marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            last_q <= 1'b0;
        end else if (st == ST_FETCH && lw_ack) begin
            hold_q <= lw_data;
            last_q <= lw_last;
        end
    end

    // Handshake outputs and beat/ending pulses.
    always_comb begin
        lw_req   = (st == ST_FETCH);
        rb_req   = (st == ST_PUSH);
        lw_addr  = laddr;
        rb_addr  = raddr;
        rb_wdata = hold_q;
        busy     = (st != ST_IDLE);
        fin_berr = rb_req && rb_berr;
        beat     = rb_req && rb_ack && !rb_berr;
        fin_done = beat && cnt_last && last_q;
        fin_ovr  = beat && cnt_last && !last_q;
    end

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lw_req && rb_req));
    a_r13_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_ack && !rb_berr) |=> rb_req && $stable(rb_addr) && $stable(rb_wdata));
    a_r13_lw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_req && !lw_ack) |=> lw_req && $stable(lw_addr));
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> lw_req && busy);
endmodule

// File: rtl/dma_chan.sv
// Top of the single-channel bus-master DMA controller: joins the register
// file and the transfer sequencer. Assumes a single clock domain and a
// 32-bit register port.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 20,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wen,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          lw_req,
    output logic [AW-1:0] lw_addr,
    input  logic          lw_ack,
    input  logic [DW-1:0] lw_data,
    input  logic          lw_last,
    output logic          rb_req,
    output logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_wdata,
    input  logic          rb_ack,
    input  logic          rb_berr,
    output logic          irq
);
    logic          busy, beat, fin_done, fin_ovr, fin_berr, start, cnt_last;
    logic [AW-1:0] laddr, raddr;

    dma_chan_regs #(.AW(AW), .CW(CW), .RW(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .beat(beat),
        .fin_done(fin_done), .fin_ovr(fin_ovr), .fin_berr(fin_berr),
        .start(start), .laddr(laddr), .raddr(raddr), .cnt_last(cnt_last),
        .irq(irq)
    );

    dma_chan_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .laddr(laddr),
        .raddr(raddr), .cnt_last(cnt_last), .lw_req(lw_req),
        .lw_addr(lw_addr), .lw_ack(lw_ack), .lw_data(lw_data),
        .lw_last(lw_last), .rb_req(rb_req), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .rb_ack(rb_ack), .rb_berr(rb_berr),
        .busy(busy), .beat(beat), .fin_done(fin_done), .fin_ovr(fin_ovr),
        .fin_berr(fin_berr)
    );
endmodule

// File: tb/sim_dma_chan.sv
// Bench: behavioural model updated on each rising edge, compared with the
// outputs 1 ns before the next one; scripted scenarios add named checks.
module sim_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lw_req, rb_req, irq;
    logic [31:0] lw_addr, rb_addr, rb_wdata;
    logic        lw_ack = 1'b0, lw_last = 1'b0, rb_ack = 1'b0, rb_berr = 1'b0;
    logic [31:0] lw_data = '0;

    int total = 0, bad = 0, cyc = 0, irq_cnt = 0;
    int src_left = 0, push_idx = 0, berr_beat = -1;
    bit stall_mode = 1'b0;

    // reference model state
    logic [31:0] m_lar, m_var, m_buf;
    logic [19:0] m_cnt;
    bit m_done, m_fb, m_fo, m_be, m_rdy, m_cfg, m_last, m_irq;
    int m_ph;

    always #4 clk = ~clk;

    dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lw_req(lw_req),
        .lw_addr(lw_addr), .lw_ack(lw_ack), .lw_data(lw_data),
        .lw_last(lw_last), .rb_req(rb_req), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .rb_ack(rb_ack), .rb_berr(rb_berr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] mread(input logic [3:0] a);
        logic [31:0] c;
        c = '0;
        c[1] = m_done; c[2] = m_fb; c[3] = m_fo; c[4] = (m_ph != 0);
        c[5] = m_be; c[12] = m_rdy; c[16] = m_cfg;
        case (a)
            4'h0: return m_lar;
            4'h4: return m_var;
            4'h8: return {12'b0, m_cnt};
            4'hC: return c;
            default: return '0;
        endcase
    endfunction

    // Model: advances from the inputs held across the rising edge.
    always @(posedge clk) begin
        int ph0;
        bit ob;
        cyc++;
        if (!rst_n) begin
            m_lar = '0; m_var = '0; m_cnt = '0; m_buf = '0;
            m_done = 0; m_fb = 0; m_fo = 0; m_be = 0; m_rdy = 0; m_cfg = 0;
            m_last = 0; m_irq = 0; m_ph = 0;
        end else begin
            ph0 = m_ph;
            ob = (m_ph != 0);
            m_irq = 0;
            if (reg_wen) begin
                case (reg_addr)
                    4'h0: if (!ob) m_lar = reg_wdata;
                    4'h4: if (!ob) m_var = reg_wdata;
                    4'h8: if (!ob) m_cnt = reg_wdata[19:0];
                    4'hC: begin
                        if (!reg_wdata[1])  m_done = 0;
                        if (!reg_wdata[2])  m_fb = 0;
                        if (!reg_wdata[3])  m_fo = 0;
                        if (!reg_wdata[5])  m_be = 0;
                        if (!reg_wdata[16]) m_cfg = 0;
                        m_rdy = reg_wdata[12];
                        if (reg_wdata[0]) begin
                            if (reg_wdata[12] && m_cnt != 0 && !ob) m_ph = 1;
                            else m_cfg = 1;
                        end
                    end
                    default: ;
                endcase
            end
            if (ph0 == 1 && lw_ack) begin
                m_buf = lw_data; m_last = lw_last; m_ph = 2;
            end else if (ph0 == 2) begin
                if (rb_berr) begin
                    m_be = 1; m_fb = 1; m_ph = 0; m_irq = 1;
                end else if (rb_ack) begin
                    m_lar = m_lar + 4; m_var = m_var + 4; m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        if (m_last) m_done = 1; else m_fo = 1;
                        m_ph = 0; m_irq = 1;
                    end else m_ph = 1;
                end
            end
        end
    end

    // Responder on the falling edge, then per-cycle comparison 1 ns before rise.
    always @(negedge clk) begin
        bit ok;
        lw_ack = 0; lw_last = 0; lw_data = '0; rb_ack = 0; rb_berr = 0;
        if (rst_n) begin
            ok = !stall_mode || (cyc % 3 != 0);
            if (lw_req && ok) begin
                lw_ack = 1; lw_data = ~lw_addr; lw_last = (src_left == 1); src_left--;
            end
            if (rb_req && ok) begin
                if (push_idx == berr_beat) rb_berr = 1; else rb_ack = 1;
                push_idx++;
            end
        end
        #3;
        if (rst_n) begin
            chk("R13 lw_req", {31'b0, lw_req}, {31'b0, m_ph == 1});
            chk("R13 rb_req", {31'b0, rb_req}, {31'b0, m_ph == 2});
            if (m_ph == 1) chk("R5 lw_addr", lw_addr, m_lar);
            if (m_ph == 2) begin
                chk("R5 rb_addr", rb_addr, m_var);
                chk("R5 rb_wdata", rb_wdata, m_buf);
            end
            chk("R12 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R2 rdata", reg_rdata, mread(reg_addr));
            if (irq === 1'b1) irq_cnt++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2 v = reg_rdata;
    endtask

    task automatic wait_idle();
        while (m_ph != 0) @(negedge clk);
    endtask

    task automatic arm(input int src, input int eb, input bit st);
        src_left = src; push_idx = 0; berr_beat = eb; stall_mode = st;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc == 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int i0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v); chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        // R2 register map and count width
        wr(4'h0, 32'h0000_1000);
        wr(4'h4, 32'h8000_0000);
        wr(4'h8, 32'hFFFA_BCDE);
        rd(4'h8, v); chk("R2 count width", v, 32'h000A_BCDE);
        rd(4'h4, v); chk("R2 remote addr", v, 32'h8000_0000);
        wr(4'h8, 32'd4);
        // R4 start without gate bit
        wr(4'hC, 32'h0000_0001);
        chk("R4 no launch", {31'b0, lw_req}, 32'h0);
        rd(4'hC, v); chk("R4 gate refused", v, 32'h0001_0000);
        // R10 write zero clears
        wr(4'hC, 32'h0);
        rd(4'hC, v); chk("R10 cleared", v, 32'h0);
        // Transfer A: 4 words, source ends exactly
        arm(4, -1, 0);
        i0 = irq_cnt;
        wr(4'hC, 32'h0000_1001);
        chk("R3 launch", {31'b0, lw_req}, 32'h1);
        wait_idle();
        rd(4'hC, v); chk("R6 done", v, 32'h0000_1002);
        rd(4'h0, v); chk("R5 local adv", v, 32'h0000_1010);
        rd(4'h4, v); chk("R5 remote adv", v, 32'h8000_0010);
        rd(4'h8, v); chk("R6 count zero", v, 32'h0);
        chk("R12 one pulse", irq_cnt - i0, 1);
        // Transfer B: stalls, writes while busy, remote address not rewritten
        wr(4'hC, 32'h0000_1000);
        wr(4'h8, 32'd3);
        wr(4'h0, 32'h0000_2000);
        arm(3, -1, 1);
        wr(4'hC, 32'h0000_1001);
        wr(4'h0, 32'hDEAD_0000);
        wr(4'h8, 32'd9);
        wr(4'hC, 32'h0000_1001);
        wait_idle();
        rd(4'h0, v); chk("R11 busy write ignored", v, 32'h0000_200C);
        rd(4'h4, v); chk("R9 remote continues", v, 32'h8000_001C);
        rd(4'hC, v); chk("R4 busy start flagged", v, 32'h0001_1002);
        // Transfer C: overrun
        wr(4'hC, 32'h0000_1000);
        wr(4'h8, 32'd2);
        arm(5, -1, 0);
        wr(4'hC, 32'h0000_1001);
        wait_idle();
        rd(4'hC, v); chk("R7 overrun", v, 32'h0000_1008);
        // Transfer D: bus error on third beat
        wr(4'hC, 32'h0000_1000);
        wr(4'h0, 32'h0000_3000);
        wr(4'h4, 32'h4000_0000);
        wr(4'h8, 32'd5);
        arm(5, 2, 0);
        i0 = irq_cnt;
        wr(4'hC, 32'h0000_1001);
        wait_idle();
        rd(4'hC, v); chk("R8 error flags", v, 32'h0000_1024);
        rd(4'h8, v); chk("R8 count frozen", v, 32'd3);
        rd(4'h4, v); chk("R8 remote frozen", v, 32'h4000_0008);
        rd(4'h0, v); chk("R8 local frozen", v, 32'h0000_3008);
        chk("R12 error pulse", irq_cnt - i0, 1);
        // R10 sticky behaviour
        wr(4'hC, 32'h0000_1024);
        rd(4'hC, v); chk("R10 ones keep", v, 32'h0000_1024);
        wr(4'hC, 32'h0000_1020);
        rd(4'hC, v); chk("R10 partial clear", v, 32'h0000_1020);
        wr(4'hC, 32'h0000_0020);
        rd(4'hC, v); chk("R10 gate bit rw", v, 32'h0000_0020);
        // R4 zero count refused
        wr(4'hC, 32'h0);
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h0000_1001);
        chk("R4 zero count no launch", {31'b0, lw_req}, 32'h0);
        rd(4'hC, v); chk("R4 zero count", v, 32'h0001_1000);
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule